// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Data Cache

This block is a small, fully associative store that sits beside a direct-mapped data cache and keeps the lines that cache throws away when it misses. When the primary cache misses, its controller presents the missing block address together with the line it is about to discard. The buffer compares the address against every stored entry at once, using the whole block address as the tag. A match returns the stored line to the primary cache, and the discarded line takes the freed slot (a swap). No match raises a request toward the next memory level, and the discarded line is stored.

Stored lines keep their dirty state. When the buffer is full, a new line displaces the entry that was inserted longest ago. If that displaced entry is dirty, it leaves on a writeback port. All results appear on registered outputs one clock after the request.

Top module: `victim_cache`

## Requirements
- R1: After reset no entry is held, all outputs are low, and the first lookup misses.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: A lookup whose address equals a held entry's address gives `rsp_hit`=1, that entry's data on `rsp_data`, its dirty bit on `rsp_dirty`, and `next_req`=0.
- R4: A lookup matching no held entry gives `rsp_hit`=0 and `next_req`=1, with `next_addr` equal to the looked-up address.
- R5: On a hit with `evict_valid`=1, the discarded line (address, data, dirty bit) takes the hit entry's place, and the returned line is no longer held.
- R6: On a hit with `evict_valid`=0, the hit entry is freed, so a repeated lookup of that address misses.
- R7: On a miss with `evict_valid`=1 while fewer than ENTRIES lines are held, the line is stored and nothing is displaced (`wb_valid` stays 0).
- R8: On a miss with `evict_valid`=1 while full, the displaced entry is the one inserted longest ago; a swap on a hit counts as a fresh insertion.
- R9: A displaced dirty entry appears with `wb_valid`=1 and its address and data on `wb_addr`/`wb_data` in the cycle after the request. A displaced clean entry causes no writeback.
- R10: With `req_valid`=0 the evict inputs are ignored and no line is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Primary cache missed; look up `req_addr` |
| req_addr | input | ADDR_W | Block address of the missing line |
| evict_valid | input | 1 | A line is being discarded from the primary cache |
| evict_addr | input | ADDR_W | Block address of the discarded line |
| evict_dirty | input | 1 | Discarded line is modified |
| evict_data | input | DATA_W | Discarded line contents |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Line found in the buffer |
| rsp_dirty | output | 1 | Dirty bit of the returned line |
| rsp_data | output | DATA_W | Returned line contents (zero on a miss) |
| next_req | output | 1 | Fetch request to the next memory level |
| next_addr | output | ADDR_W | Block address for the next-level fetch |
| wb_valid | output | 1 | Displaced dirty line is being written back |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Contents of the written-back line |

## Verification
Every result (hit flag, returned data and dirty bit, next-level request and writeback) is registered once, so each is due in the single cycle after the request cycle. The bench drives one transaction just after a rising edge, waits for the next rising edge, and compares all outputs one nanosecond later against a model. The model tracks held lines by insertion order, not by slot index. An idle cycle in between shows that every output drops back to zero.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Insertion age: 0 = newest. Valid entries hold distinct ages 0..count-1.
  typedef logic [7:0] vc_age_t;

  // A line enters a slot whose former age was ref_a (ENTRIES if the slot was empty):
  // every valid entry younger than that ages by one.
  function automatic vc_age_t age_on_insert(vc_age_t a, logic v, vc_age_t ref_a);
    return (v && a < ref_a) ? vc_age_t'(a + 8'd1) : a;
  endfunction

  // An entry of age gone_a leaves without replacement: older entries close the gap.
  function automatic vc_age_t age_on_free(vc_age_t a, logic v, vc_age_t gone_a);
    return (v && a > gone_a) ? vc_age_t'(a - 8'd1) : a;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]             addr,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          hit_any,
  output logic [IW-1:0]                 hit_idx,
  output logic                          free_any,
  output logic [IW-1:0]                 free_idx
);
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == addr);
    end
  endgenerate

  assign hit_any  = |hit_vec;
  assign free_any = ~&valid;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx  = IW'(i);
      if (!valid[i])  free_idx = IW'(i);
    end
  end

  // R3: an address is held at most once
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));
endmodule

// File: rtl/vc_age.sv
module vc_age
  import vc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               ins_en,
  input  logic [IW-1:0]      ins_slot,
  input  logic               free_en,
  input  logic [IW-1:0]      free_slot,
  output logic [IW-1:0]      oldest_idx
);
  vc_age_t age [ENTRIES];
  vc_age_t ref_age;
  logic [ENTRIES-1:0] oldest_vec;

  assign ref_age = valid[ins_slot] ? age[ins_slot] : vc_age_t'(ENTRIES);

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_age
      assign oldest_vec[g] = valid[g] && (age[g] == vc_age_t'(ENTRIES - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          age[g] <= '0;
        end else if (ins_en) begin
          age[g] <= (IW'(g) == ins_slot) ? '0 : age_on_insert(age[g], valid[g], ref_age);
        end else if (free_en && IW'(g) != free_slot) begin
          age[g] <= age_on_free(age[g], valid[g], age[free_slot]);
        end
      end
    end
  endgenerate

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest_vec[i]) oldest_idx = IW'(i);
  end

  // R8: with every slot held, exactly one entry is the oldest
  a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid) |-> ($countones(oldest_vec) == 1));
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              evict_dirty,
  input  logic [DATA_W-1:0] evict_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_dirty,
  output logic [DATA_W-1:0] rsp_data,
  output logic              next_req,
  output logic [ADDR_W-1:0] next_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q, dirty_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;

  // named internal events
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any, free_any, lookup_hit, ins_en, free_en, push_out;
  logic [IW-1:0]      hit_idx, free_idx, oldest_idx, ins_slot;

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .tags(tag_q), .addr(req_addr),
    .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx),
    .free_any(free_any), .free_idx(free_idx)
  );

  assign lookup_hit = req_valid && hit_any;
  assign ins_en     = req_valid && evict_valid;
  assign free_en    = lookup_hit && !evict_valid;
  assign push_out   = req_valid && !hit_any && evict_valid && !free_any;
  assign ins_slot   = hit_any ? hit_idx : (free_any ? free_idx : oldest_idx);

  vc_age #(.ENTRIES(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .valid(valid_q),
    .ins_en(ins_en), .ins_slot(ins_slot),
    .free_en(free_en), .free_slot(hit_idx),
    .oldest_idx(oldest_idx)
  );

  // entry state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (ins_en) begin
      valid_q[ins_slot] <= 1'b1;
      dirty_q[ins_slot] <= evict_dirty;
    end else if (free_en) begin
      valid_q[hit_idx] <= 1'b0;
      dirty_q[hit_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[ins_slot]  <= evict_addr;
      data_q[ins_slot] <= evict_data;
    end
  end

  // registered results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_data  <= '0;
      next_req  <= 1'b0;
      next_addr <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= lookup_hit;
      rsp_dirty <= lookup_hit && dirty_q[hit_idx];
      rsp_data  <= lookup_hit ? data_q[hit_idx] : '0;
      next_req  <= req_valid && !hit_any;
      next_addr <= (req_valid && !hit_any) ? req_addr : '0;
      wb_valid  <= push_out && dirty_q[oldest_idx];
      wb_addr   <= (push_out && dirty_q[oldest_idx]) ? tag_q[oldest_idx] : '0;
      wb_data   <= (push_out && dirty_q[oldest_idx]) ? data_q[oldest_idx] : '0;
    end
  end

  // R2: one result per request, one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4: the next level is asked exactly on a lookup miss
  a_r4_miss_goes_next: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (next_req == !rsp_hit));
  // R6: a hit with nothing to store frees that entry
  a_r6_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> !valid_q[$past(hit_idx)]);
  // R9: writebacks only follow a missed lookup
  a_r9_wb_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && !rsp_hit));
  // R10: no storage change without a request
  a_r10_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(valid_q));
endmodule

// File: tb/victim_cache_test.sv
`timescale 1ns/1ps
module victim_cache_test;
  localparam int N  = 8;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, evict_valid = 1'b0, evict_dirty = 1'b0;
  logic [AW-1:0] req_addr = '0, evict_addr = '0;
  logic [DW-1:0] evict_data = '0;
  logic rsp_valid, rsp_hit, rsp_dirty, next_req, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] next_addr, wb_addr;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  victim_cache #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_dirty(evict_dirty),
    .evict_data(evict_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_dirty(rsp_dirty), .rsp_data(rsp_data), .next_req(next_req),
    .next_addr(next_addr), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  // reference model, ordered by insertion stamp
  bit          m_v [N];
  logic [AW-1:0] m_a [N];
  logic [DW-1:0] m_d [N];
  bit          m_dy [N];
  int          m_st [N];
  int          stamp = 0;

  function automatic int m_find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction
  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    return -1;
  endfunction
  function automatic int m_oldest();
    int k = 0;
    for (int i = 1; i < N; i++) if (m_st[i] < m_st[k]) k = i;
    return k;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic txn(string tag, bit rq, logic [AW-1:0] a, bit ev,
                     logic [AW-1:0] ea, logic [DW-1:0] ed, bit edy);
    int h, s;
    bit e_hit, e_dy, e_wb;
    logic [DW-1:0] e_d, e_wd;
    logic [AW-1:0] e_wa;
    h = rq ? m_find(a) : -1;
    e_hit = (h >= 0);
    e_d = e_hit ? m_d[h] : '0;
    e_dy = e_hit ? m_dy[h] : 1'b0;
    e_wb = 1'b0; e_wa = '0; e_wd = '0;
    s = -1;
    if (rq && ev) begin
      if (e_hit) s = h;
      else begin
        s = m_free();
        if (s < 0) begin
          s = m_oldest();
          if (m_dy[s]) begin e_wb = 1'b1; e_wa = m_a[s]; e_wd = m_d[s]; end
        end
      end
    end
    req_valid = rq; req_addr = a; evict_valid = ev;
    evict_addr = ea; evict_data = ed; evict_dirty = edy;
    @(posedge clk); #1;
    req_valid = 1'b0; evict_valid = 1'b0;
    chk({tag, "/R2"}, "rsp_valid", rsp_valid, rq);
    if (rq) begin
      chk({tag, e_hit ? "/R3" : "/R4"}, "rsp_hit", rsp_hit, e_hit);
      chk({tag, "/R3"}, "rsp_data", rsp_data, e_d);
      chk({tag, "/R3"}, "rsp_dirty", rsp_dirty, e_dy);
      chk({tag, "/R4"}, "next_req", next_req, !e_hit);
      chk({tag, "/R4"}, "next_addr", next_addr, e_hit ? '0 : a);
    end else begin
      chk({tag, "/R10"}, "next_req", next_req, 0);
    end
    chk({tag, "/R9"}, "wb_valid", wb_valid, e_wb);
    if (e_wb) begin
      chk({tag, "/R9"}, "wb_addr", wb_addr, e_wa);
      chk({tag, "/R9"}, "wb_data", wb_data, e_wd);
    end
    // model update
    if (s >= 0) begin
      m_v[s] = 1; m_a[s] = ea; m_d[s] = ed; m_dy[s] = edy; m_st[s] = stamp++;
    end else if (e_hit) begin
      m_v[h] = 0; m_dy[h] = 0; m_st[h] = 0;
    end
  endtask

  function automatic bit m_held(logic [AW-1:0] a);
    return m_find(a) >= 0;
  endfunction

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_st[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "next_req", next_req, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    txn("R1", 1, 12'h005, 0, '0, '0, 0);

    // R7: fill all slots, no writeback while space remains
    for (int i = 0; i < N; i++)
      txn("R7", 1, 12'h700 + AW'(i), 1, 12'h100 + AW'(i), 32'hA000_0000 + i, i[0]);

    // R5: swap on hit
    txn("R5", 1, 12'h103, 1, 12'h200, 32'hBEEF_0200, 1);
    txn("R5", 1, 12'h103, 0, '0, '0, 0);
    // R6: hit without a line to store frees the entry
    txn("R6", 1, 12'h200, 0, '0, '0, 0);
    txn("R6", 1, 12'h200, 0, '0, '0, 0);
    // R7: one free slot again
    txn("R7", 1, 12'h710, 1, 12'h300, 32'hC300, 0);
    // R8/R9: full, displace oldest (clean 0x100, then dirty 0x101)
    txn("R8", 1, 12'h711, 1, 12'h301, 32'hC301, 1);
    txn("R9", 1, 12'h712, 1, 12'h302, 32'hC302, 0);
    txn("R8", 1, 12'h713, 1, 12'h303, 32'hC303, 0);
    // R10: idle cycle with evict inputs, then look for the line
    txn("R10", 0, '0, 1, 12'h400, 32'hDEAD, 1);
    txn("R10", 1, 12'h400, 0, '0, '0, 0);

    // constrained random traffic on a small address pool
    for (int t = 0; t < 3000; t++) begin
      logic [AW-1:0] a, ea;
      bit rq, ev;
      rq = ($urandom % 8) != 0;
      a  = AW'($urandom % 24);
      ev = ($urandom % 4) != 0;
      ea = a;
      for (int k = 0; k < 40 && (ea == a || m_held(ea)); k++) ea = AW'($urandom % 24);
      if (ea == a || m_held(ea)) ev = 0;
      txn(rq ? "R8" : "R10", rq, a, ev, ea, $urandom, $urandom % 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule